// File: doc/BRIEF.md
# LIN Header Break and Sync Detector

This block sits on the receive line of a LIN-capable serial port while a slave node waits for a frame header from the master. It watches the line, after synchronization, for a low period long enough to count as a break, and records the break in a sticky flag. It then follows the falling edges of the synchronization byte that comes next.

A measurement window opens on the first of those edges and closes on the fifth. While it is open, the block counts clock cycles. When the fifth edge arrives, it latches the cycle count and pulses a done strobe. The sync byte is 0x55 sent least significant bit first, so its first and fifth falling edges are eight bit periods apart. Software or a baud tracker divides the count by eight to get the master's real bit period in clock cycles.

The nominal bit time is a programmed input. It sets both the break threshold and the limit after which a window that never reaches its fifth edge is abandoned.

Top module: `lin_hdr_detect`

## Requirements
- R1: With detection enabled, the break flag sets when the synchronized line has been low for 11 × `bit_time_i` consecutive cycles. A low run one cycle shorter does not set it. `bit_time_i` must be nonzero.
- R2: While `brk_en_i` is 0, a low run of any length leaves the break flag at 0.
- R3: The break flag holds until `brk_clr_i` is high for a cycle. If a clear and a new detection fall in the same cycle, the flag stays 1.
- R4: After a detected break, the detector arms once the line has returned high. The first falling edge after that raises `win_o`. Falling edges that have no detected break before them never raise `win_o`.
- R5: `win_o` drops after the fifth falling edge, counting the edge that opened it. The number of cycles it stays high equals the number of cycles between the first and fifth edges.
- R6: On the fifth edge, `meas_o` takes the number of cycles the window was high, and `done_o` pulses for exactly one cycle, in the same cycle that `win_o` falls. For a 0x55 sync byte with a bit period of P cycles, `meas_o` equals 8 × P.
- R7: If the fifth edge has not arrived 16 × `bit_time_i` cycles after the first edge, the window closes after exactly that many high cycles. No done pulse is given, `meas_o` keeps its previous value, and a new break is needed to arm again.
- R8: `rxd_i` passes through a two-flop synchronizer. Synchronous reset `rst` clears the flag, the window, the count and the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd_i | input | 1 | Serial receive line, idle high, asynchronous |
| bit_time_i | input | BIT_W | Nominal bit period in clock cycles |
| brk_en_i | input | 1 | Enables break detection |
| brk_clr_i | input | 1 | One-cycle strobe that clears the break flag |
| brk_flag_o | output | 1 | Sticky break-detected flag |
| win_o | output | 1 | Measurement window, first to fifth sync falling edge |
| meas_o | output | CNT_W | Latched window width in clock cycles |
| done_o | output | 1 | One-cycle pulse when `meas_o` is updated |

## Verification
A low level on `rxd_i` reaches the synchronized line two edges later. The break flag therefore rises 11 × `bit_time_i` + 2 edges after the line first falls. `win_o` rises three edges after the first sync falling edge. It falls, together with the `done_o` pulse and the new `meas_o`, three edges after the fifth edge. The bench does not time single edges. It samples on falling clock edges and counts the cycles in which the window, done pulse and flag are high, and it compares those counts after an idle tail of several bit times that covers the pipeline. The flag's clear-versus-detect priority is checked by holding the clear strobe high through a break and expecting the flag to be seen high for exactly one cycle.

// File: rtl/lin_hdr_pkg.sv
`timescale 1ns/1ps
package lin_hdr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_HI = 2'd1,
        ST_ARMED   = 2'd2,
        ST_WIN     = 2'd3
    } win_st_e;
endpackage

// File: rtl/lin_rx_sync.sv
`timescale 1ns/1ps
// Synchronizer chain on the receive line, plus falling-edge detection on its output.
module lin_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd_i,
    output logic rx_s,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t q, d;

    always_comb begin
        d       = q;
        d.chain = {q.chain[STAGES-2:0], rxd_i};
        d.prev  = q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.chain <= '1;
            q.prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_s = q.chain[STAGES-1];
    assign fall = q.prev & ~q.chain[STAGES-1];
endmodule

// File: rtl/lin_brk_det.sv
`timescale 1ns/1ps
// Measures runs of low level on the synchronized line and keeps the sticky break flag.
module lin_brk_det #(
    parameter int BIT_W    = 16,
    parameter int BRK_BITS = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_s,
    input  logic             en,
    input  logic             clr,
    input  logic [BIT_W-1:0] bit_time,
    output logic             hit,
    output logic             flag
);
    localparam int LOW_W = BIT_W + $clog2(BRK_BITS + 1);

    typedef struct packed {
        logic [LOW_W-1:0] low;
        logic             flag;
    } brk_st_t;

    brk_st_t          q, d;
    logic [LOW_W-1:0] thr;

    assign thr = LOW_W'(BRK_BITS) * LOW_W'(bit_time);

    always_comb begin
        d   = q;
        hit = en & ~rx_s & (q.low == thr - LOW_W'(1));
        if (rx_s)
            d.low = '0;
        else if (q.low < thr)
            d.low = q.low + LOW_W'(1);
        d.flag = hit | (q.flag & ~clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign flag = q.flag;

    assert_flag_cause_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(q.flag) |-> $past(hit));
    assert_flag_wins_R3: assert property (@(posedge clk) disable iff (rst)
        hit |=> q.flag);
    assert_no_hit_disabled_R2: assert property (@(posedge clk) disable iff (rst)
        !en |-> !hit);
endmodule

// File: rtl/lin_sync_win.sv
`timescale 1ns/1ps
// Arms after a break and counts sync-field falling edges. Times the window, latches the count, aborts on timeout.
module lin_sync_win
    import lin_hdr_pkg::*;
#(
    parameter int BIT_W    = 16,
    parameter int CNT_W    = 20,
    parameter int EDGES    = 5,
    parameter int TMO_BITS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_s,
    input  logic             fall,
    input  logic             hit,
    input  logic [BIT_W-1:0] bit_time,
    output logic             win,
    output logic [CNT_W-1:0] meas,
    output logic             done
);
    localparam int EW = $clog2(EDGES + 1);

    typedef struct packed {
        win_st_e          st;
        logic             win;
        logic [CNT_W-1:0] cnt;
        logic [EW-1:0]    edges;
        logic [CNT_W-1:0] meas;
        logic             done;
    } win_st_t;

    win_st_t          q, d;
    logic [CNT_W-1:0] tmo;

    assign tmo = CNT_W'(TMO_BITS) * CNT_W'(bit_time);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (hit) begin
            d.st  = ST_WAIT_HI;
            d.win = 1'b0;
        end else begin
            unique case (q.st)
                ST_WAIT_HI: if (rx_s) d.st = ST_ARMED;
                ST_ARMED: if (fall) begin
                    d.st    = ST_WIN;
                    d.win   = 1'b1;
                    d.cnt   = CNT_W'(1);
                    d.edges = EW'(1);
                end
                ST_WIN: begin
                    if (fall && q.edges == EW'(EDGES - 1)) begin
                        d.meas = q.cnt;
                        d.done = 1'b1;
                        d.win  = 1'b0;
                        d.st   = ST_IDLE;
                    end else if (q.cnt >= tmo) begin
                        d.win = 1'b0;
                        d.st  = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                        if (fall) d.edges = q.edges + EW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{st: ST_IDLE, win: 1'b0, cnt: '0, edges: '0, meas: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign win  = q.win;
    assign meas = q.meas;
    assign done = q.done;

    assert_win_opens_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(q.win) |-> $past(fall));
    assert_done_closes_win_R6: assert property (@(posedge clk) disable iff (rst)
        q.done |-> (!q.win && $past(q.win)));
    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        q.done |=> !q.done);
    assert_win_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        q.win |-> (q.cnt <= tmo));
endmodule

// File: rtl/lin_hdr_detect.sv
`timescale 1ns/1ps
module lin_hdr_detect #(
    parameter int BIT_W    = 16,
    parameter int CNT_W    = 20,
    parameter int SYNC_FF  = 2,
    parameter int BRK_BITS = 11,
    parameter int EDGES    = 5,
    parameter int TMO_BITS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd_i,
    input  logic [BIT_W-1:0] bit_time_i,
    input  logic             brk_en_i,
    input  logic             brk_clr_i,
    output logic             brk_flag_o,
    output logic             win_o,
    output logic [CNT_W-1:0] meas_o,
    output logic             done_o
);
    logic rx_s, fall, hit;

    lin_rx_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .rxd_i(rxd_i),
        .rx_s (rx_s),
        .fall (fall)
    );

    lin_brk_det #(.BIT_W(BIT_W), .BRK_BITS(BRK_BITS)) u_brk (
        .clk     (clk),
        .rst     (rst),
        .rx_s    (rx_s),
        .en      (brk_en_i),
        .clr     (brk_clr_i),
        .bit_time(bit_time_i),
        .hit     (hit),
        .flag    (brk_flag_o)
    );

    lin_sync_win #(.BIT_W(BIT_W), .CNT_W(CNT_W), .EDGES(EDGES), .TMO_BITS(TMO_BITS)) u_win (
        .clk     (clk),
        .rst     (rst),
        .rx_s    (rx_s),
        .fall    (fall),
        .hit     (hit),
        .bit_time(bit_time_i),
        .win     (win_o),
        .meas    (meas_o),
        .done    (done_o)
    );
endmodule

// File: tb/sim_lin_hdr_detect.sv
`timescale 1ns/1ps
module sim_lin_hdr_detect;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd_i = 1'b1;
    logic [15:0] bit_time_i = 16'd10;
    logic        brk_en_i = 1'b1;
    logic        brk_clr_i = 1'b0;
    logic        brk_flag_o, win_o, done_o;
    logic [19:0] meas_o;

    int total = 0, fails = 0;
    int win_n = 0, done_n = 0, flag_n = 0;

    always #2.5 clk = ~clk;

    lin_hdr_detect u0 (
        .clk(clk), .rst(rst), .rxd_i(rxd_i), .bit_time_i(bit_time_i),
        .brk_en_i(brk_en_i), .brk_clr_i(brk_clr_i), .brk_flag_o(brk_flag_o),
        .win_o(win_o), .meas_o(meas_o), .done_o(done_o)
    );

    always @(negedge clk) begin
        if (win_o) win_n++;
        if (done_o) done_n++;
        if (brk_flag_o) flag_n++;
    end

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic line(logic v, int n);
        rxd_i = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic zero_counts();
        @(posedge clk);
        win_n = 0; done_n = 0; flag_n = 0;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        brk_clr_i = 1'b1;
        @(negedge clk);
        brk_clr_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_break(int low_len, int t);
        line(1'b0, low_len);
        line(1'b1, t);
    endtask

    task automatic send_sync(int t);
        line(1'b0, t);
        for (int i = 0; i < 8; i++) line((i % 2 == 0) ? 1'b1 : 1'b0, t);
        line(1'b1, t + 8);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 flag in reset", brk_flag_o, 0);
        chk("R8 win in reset", win_o, 0);
        chk("R8 done in reset", done_o, 0);
        chk("R8 meas in reset", meas_o, 0);
        rst = 1'b0;
        line(1'b1, 5);
    endtask

    task automatic t_nominal();
        bit_time_i = 16'd10;
        send_break(130, 10);
        chk("R1 flag after break", brk_flag_o, 1);
        zero_counts();
        send_sync(10);
        chk("R6 meas nominal", meas_o, 80);
        chk("R5 window width", win_n, 80);
        chk("R6 done pulse width", done_n, 1);
        chk("R5 window closed", win_o, 0);
        chk("R3 flag still held", brk_flag_o, 1);
    endtask

    task automatic t_clear();
        pulse_clr();
        chk("R3 flag cleared", brk_flag_o, 0);
    endtask

    task automatic t_no_break();
        zero_counts();
        send_sync(10);
        chk("R4 no window without break", win_n, 0);
        chk("R4 no done without break", done_n, 0);
    endtask

    task automatic t_disabled();
        brk_en_i = 1'b0;
        send_break(200, 10);
        chk("R2 no flag when disabled", brk_flag_o, 0);
        brk_en_i = 1'b1;
    endtask

    task automatic t_threshold();
        send_break(109, 10);
        chk("R1 one cycle short", brk_flag_o, 0);
        send_break(110, 10);
        chk("R1 exact threshold", brk_flag_o, 1);
        pulse_clr();
    endtask

    task automatic t_fast_master();
        send_break(130, 9);
        zero_counts();
        send_sync(9);
        chk("R6 meas fast master", meas_o, 72);
        chk("R5 width fast master", win_n, 72);
        chk("R6 done fast master", done_n, 1);
    endtask

    task automatic t_timeout();
        send_break(130, 10);
        zero_counts();
        line(1'b0, 10); line(1'b1, 10);
        line(1'b0, 10); line(1'b1, 10);
        line(1'b0, 10); line(1'b1, 300);
        chk("R7 window aborted width", win_n, 160);
        chk("R7 no done on timeout", done_n, 0);
        chk("R7 meas kept", meas_o, 72);
        zero_counts();
        send_sync(10);
        chk("R7 not armed after abort", win_n, 0);
    endtask

    task automatic t_collide();
        pulse_clr();
        zero_counts();
        brk_clr_i = 1'b1;
        send_break(115, 10);
        brk_clr_i = 1'b0;
        @(negedge clk);
        chk("R3 detect wins over clear", flag_n, 1);
        chk("R3 then cleared", brk_flag_o, 0);
    endtask

    task automatic t_recover();
        bit_time_i = 16'd6;
        send_break(70, 6);
        chk("R1 flag with bit time 6", brk_flag_o, 1);
        zero_counts();
        send_sync(6);
        chk("R6 meas bit time 6", meas_o, 48);
        chk("R6 done bit time 6", done_n, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_nominal();
        t_clear();
        t_no_break();
        t_disabled();
        t_threshold();
        t_fast_master();
        t_timeout();
        t_collide();
        t_recover();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end
endmodule